// File: doc/BRIEF.md
# Converter Serial Command Port

This block is the digital control front end of a data converter. An external host drives a four-wire serial link (active-low select, serial clock, data in, data out). Each transaction opens with an 8-bit command byte. Register-access commands are followed by a 32-bit data word, moved into or out of one of four internal registers: configuration, offset, gain, and the read-only conversion result. Start commands carry no data word. They raise a one-cycle strobe that tells the modulator and filter logic which conversion or calibration to run. Bytes that decode to nothing are dropped, and the port waits for the next command.

The configuration register contains a software reset request and a read-only flag that reports a valid reset. While the request is set, the calibration registers and the conversion result sit at their reset values and the other configuration bits are held at zero. The serial port keeps running throughout. Conversion results arrive on a valid/ready stream. A word is taken only when `conv_valid` and `conv_ready` are both high. `conv_ready` drops while a software reset is active and while a result readout is in progress, so the result being shifted out cannot change mid-word. A producer that sees `conv_ready` low must keep its word and `conv_valid` until `conv_ready` returns high.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After hardware reset the ports read as follows: `cfg_word`=0x00000000, `offset_word`=0x00000000, `gain_word`=0x01000000, `spi_miso`=0, `conv_ready`=1, `soft_rst`=0.
- R2: Serial data is shifted most significant bit first and sampled on the rising serial clock edge. The first 8 bits after select goes low are a command byte. Register-access bytes have the form 0000_R0SS: R=1 reads and R=0 writes, and SS selects 0 offset, 1 gain, 2 configuration, 3 conversion data. A 32-bit word follows each register-access byte.
- R3: In a read, `spi_miso` changes only after falling serial clock edges. The MSB of the selected register appears after the first falling edge that follows the command byte.
- R4: A byte of the form 1000_00KK produces exactly one `start_valid` pulse with `start_kind`=KK and has no data phase.
- R5: Any other byte, including a write to register 3, is ignored. The next 8 bits are decoded as a new command.
- R6: Raising `spi_cs_n` in the middle of a word discards the partial word, changes no register and returns the port to command mode.
- R7: Writing 1 to configuration bit 29 (reset request) has these effects: `soft_rst` goes to 1, offset is set to 0, gain is set to 0x01000000, the conversion result is set to 0, and the other configuration bits are cleared.
- R8: While bit 29 is 1, a configuration write changes only bit 29 and its data bits are ignored. Offset and gain writes and start commands are also ignored.
- R9: Configuration bit 28 (reset-valid flag) becomes 1 once bit 29 has been 1 for RST_HOLD (default 8) master clock cycles. Register writes never change bit 28.
- R10: A configuration read returns the current bit 28 and then clears it.
- R11: `conv_ready` is 0 while bit 29 is 1 and during a conversion-data readout. A word offered while `conv_ready` is 0 is not taken, and the next read returns the previously accepted result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| conv_valid | input | 1 | Conversion result offered |
| conv_ready | output | 1 | Conversion result can be taken |
| conv_data | input | 32 | Conversion result word |
| start_valid | output | 1 | One-cycle start strobe |
| start_kind | output | 2 | Conversion or calibration kind for the strobe |
| cfg_word | output | 32 | Configuration view, including bits 29 and 28 |
| offset_word | output | 32 | Offset register |
| gain_word | output | 32 | Gain register |
| soft_rst | output | 1 | Software reset request active |

## Verification
The assertions assume that `spi_sclk` stays high and low for at least four master clock cycles per phase. They also assume `spi_mosi` is stable around each rising edge and `spi_sclk` is low whenever `spi_cs_n` changes. Under those conditions every serial edge is seen exactly once after synchronization, and each read word is loaded before its first falling edge. The stimulus uses eight-cycle half periods and changes `spi_mosi` only while `spi_sclk` is low. Select is raised or lowered only with the clock idle. Stream inputs change only between clock edges.

// File: rtl/scmd_pkg.sv
package scmd_pkg;
  localparam int WORD_W = 32;
  localparam int CMD_W  = 8;
  localparam int RS_BIT = 29;
  localparam int RV_BIT = 28;
  localparam logic [WORD_W-1:0] CFG_WMASK = ~((WORD_W'(1) << RS_BIT) | (WORD_W'(1) << RV_BIT));

  typedef enum logic [1:0] {SEL_OFFSET = 2'd0, SEL_GAIN = 2'd1, SEL_CONFIG = 2'd2, SEL_DATA = 2'd3} reg_sel_e;
  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_READ, OP_START} op_e;
  typedef enum logic [1:0] {PH_CMD, PH_WRITE, PH_READ} phase_e;

  typedef struct packed {
    op_e       op;
    reg_sel_e  sel;
    logic [1:0] kind;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] b);
    cmd_dec_t d;
    d.op   = OP_NONE;
    d.sel  = reg_sel_e'(b[1:0]);
    d.kind = b[1:0];
    if (b[7:4] == 4'h0 && !b[2]) begin
      if (b[3])                       d.op = OP_READ;
      else if (b[1:0] != SEL_DATA)    d.op = OP_WRITE;
    end else if (b[7:4] == 4'h8 && b[3:2] == 2'b00) begin
      d.op = OP_START;
    end
    return d;
  endfunction
endpackage

// File: rtl/scmd_serial.sv
module scmd_serial
  import scmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int W = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_i,
  input  logic          sclk_i,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          word_phase_i,
  input  logic          tx_load_i,
  input  logic [W-1:0]  tx_word_i,
  output logic          cs_active_o,
  output logic          cmd_valid_o,
  output logic [CW-1:0] cmd_byte_o,
  output logic          word_valid_o,
  output logic [W-1:0]  word_o
);
  localparam int CNT_W = $clog2(W);

  logic [SYNC_STAGES-1:0] cs_sync, sclk_sync, mosi_sync;
  logic                   sclk_last;
  logic                   sclk_rise, sclk_fall, mosi_s;
  logic [CNT_W-1:0]       bit_cnt;
  logic [W-2:0]           rx_sh;
  logic [W-1:0]           tx_sh;
  logic                   tx_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync   <= '1;
      sclk_sync <= '0;
      mosi_sync <= '0;
      sclk_last <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n_i};
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
      sclk_last <= sclk_sync[SYNC_STAGES-1];
    end
  end

  assign cs_active_o = ~cs_sync[SYNC_STAGES-1];
  assign mosi_s      = mosi_sync[SYNC_STAGES-1];
  assign sclk_rise   = cs_active_o &  sclk_sync[SYNC_STAGES-1] & ~sclk_last;
  assign sclk_fall   = cs_active_o & ~sclk_sync[SYNC_STAGES-1] &  sclk_last;

  // receive side: MSB first, sampled on rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt      <= '0;
      rx_sh        <= '0;
      cmd_valid_o  <= 1'b0;
      cmd_byte_o   <= '0;
      word_valid_o <= 1'b0;
      word_o       <= '0;
    end else begin
      cmd_valid_o  <= 1'b0;
      word_valid_o <= 1'b0;
      if (!cs_active_o) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        rx_sh <= {rx_sh[W-3:0], mosi_s};
        if (!word_phase_i && bit_cnt == CNT_W'(CW-1)) begin
          cmd_valid_o <= 1'b1;
          cmd_byte_o  <= {rx_sh[CW-2:0], mosi_s};
          bit_cnt     <= '0;
        end else if (word_phase_i && bit_cnt == CNT_W'(W-1)) begin
          word_valid_o <= 1'b1;
          word_o       <= {rx_sh, mosi_s};
          bit_cnt      <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // transmit side: new bit after each falling edge of a word phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      tx_first <= 1'b0;
      miso_o   <= 1'b0;
    end else if (!cs_active_o) begin
      tx_sh    <= '0;
      tx_first <= 1'b0;
      miso_o   <= 1'b0;
    end else if (sclk_rise && !word_phase_i && bit_cnt == CNT_W'(CW-1)) begin
      tx_sh    <= '0;
      tx_first <= 1'b1;
      miso_o   <= 1'b0;
    end else if (tx_load_i) begin
      tx_sh    <= tx_word_i;
      tx_first <= 1'b1;
    end else if (sclk_fall && word_phase_i) begin
      if (tx_first) begin
        miso_o   <= tx_sh[W-1];
        tx_first <= 1'b0;
      end else begin
        miso_o <= tx_sh[W-2];
        tx_sh  <= {tx_sh[W-2:0], 1'b0};
      end
    end
  end

  a_r3_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active_o && $past(cs_active_o) && !$stable(miso_o)) |-> ($past(sclk_fall) || $past(sclk_rise)));
  a_r6_idle_no_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active_o |=> (!cmd_valid_o && !word_valid_o));
endmodule

// File: rtl/scmd_ctrl.sv
module scmd_ctrl
  import scmd_pkg::*;
#(
  parameter int W = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_active_i,
  input  logic          cmd_valid_i,
  input  logic [CW-1:0] cmd_byte_i,
  input  logic          word_valid_i,
  input  logic [W-1:0]  word_i,
  input  logic          rs_active_i,
  output logic          word_phase_o,
  output logic          rd_strobe_o,
  output reg_sel_e      rd_sel_o,
  output logic          wr_strobe_o,
  output reg_sel_e      wr_sel_o,
  output logic [W-1:0]  wr_data_o,
  output logic          data_readout_o,
  output logic          start_valid_o,
  output logic [1:0]    start_kind_o
);
  phase_e   phase_q;
  reg_sel_e sel_q;
  cmd_dec_t dec;

  assign dec = decode_cmd(cmd_byte_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q       <= PH_CMD;
      sel_q         <= SEL_OFFSET;
      rd_strobe_o   <= 1'b0;
      wr_strobe_o   <= 1'b0;
      wr_data_o     <= '0;
      start_valid_o <= 1'b0;
      start_kind_o  <= '0;
    end else begin
      rd_strobe_o   <= 1'b0;
      wr_strobe_o   <= 1'b0;
      start_valid_o <= 1'b0;
      if (!cs_active_i) begin
        phase_q <= PH_CMD;
      end else begin
        case (phase_q)
          PH_CMD: if (cmd_valid_i) begin
            case (dec.op)
              OP_WRITE: begin phase_q <= PH_WRITE; sel_q <= dec.sel; end
              OP_READ:  begin phase_q <= PH_READ;  sel_q <= dec.sel; rd_strobe_o <= 1'b1; end
              OP_START: if (!rs_active_i) begin
                start_valid_o <= 1'b1;
                start_kind_o  <= dec.kind;
              end
              default: ;
            endcase
          end
          PH_WRITE: if (word_valid_i) begin
            wr_strobe_o <= 1'b1;
            wr_data_o   <= word_i;
            phase_q     <= PH_CMD;
          end
          PH_READ: if (word_valid_i) phase_q <= PH_CMD;
          default: phase_q <= PH_CMD;
        endcase
      end
    end
  end

  assign word_phase_o   = (phase_q != PH_CMD);
  assign rd_sel_o       = sel_q;
  assign wr_sel_o       = sel_q;
  assign data_readout_o = (phase_q == PH_READ) && (sel_q == SEL_DATA);

  a_r4_start_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid_o |-> (phase_q == PH_CMD));
  a_r5_no_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |-> (wr_sel_o != SEL_DATA));
  a_r6_idle_cmd_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active_i |=> (phase_q == PH_CMD));
endmodule

// File: rtl/scmd_regs.sv
module scmd_regs
  import scmd_pkg::*;
#(
  parameter int W = 32,
  parameter int RST_HOLD = 8,
  parameter logic [W-1:0] GAIN_RST = 32'h0100_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_strobe_i,
  input  reg_sel_e     wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_strobe_i,
  input  reg_sel_e     rd_sel_i,
  output logic [W-1:0] rd_value_o,
  input  logic         data_readout_i,
  input  logic         conv_valid_i,
  input  logic [W-1:0] conv_data_i,
  output logic         conv_ready_o,
  output logic [W-1:0] cfg_o,
  output logic [W-1:0] offset_o,
  output logic [W-1:0] gain_o,
  output logic         sys_rst_o
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic              rs_q, rv_q;
  logic [W-1:0]      cfg_q, data_q;
  logic [HOLD_W-1:0] hold_cnt;
  logic              wr_cfg, wr_rs, rd_cfg, conv_take;

  assign wr_cfg    = wr_strobe_i && (wr_sel_i == SEL_CONFIG);
  assign wr_rs     = wr_data_i[RS_BIT];
  assign rd_cfg    = rd_strobe_i && (rd_sel_i == SEL_CONFIG);
  assign conv_ready_o = !rs_q && !data_readout_i;
  assign conv_take = conv_valid_i && conv_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q     <= 1'b0;
      rv_q     <= 1'b0;
      cfg_q    <= '0;
      offset_o <= '0;
      gain_o   <= GAIN_RST;
      data_q   <= '0;
      hold_cnt <= '0;
    end else begin
      if (wr_cfg) begin
        rs_q  <= wr_rs;
        cfg_q <= (rs_q || wr_rs) ? '0 : (wr_data_i & CFG_WMASK);
      end

      if (wr_cfg && wr_rs) begin
        offset_o <= '0;
        gain_o   <= GAIN_RST;
        data_q   <= '0;
      end else begin
        if (wr_strobe_i && wr_sel_i == SEL_OFFSET && !rs_q) offset_o <= wr_data_i;
        if (wr_strobe_i && wr_sel_i == SEL_GAIN && !rs_q)   gain_o   <= wr_data_i;
        if (conv_take) data_q <= conv_data_i;
      end

      if (wr_cfg && wr_rs && !rs_q)                 hold_cnt <= '0;
      else if (rs_q && hold_cnt != HOLD_W'(RST_HOLD)) hold_cnt <= hold_cnt + 1'b1;

      if (rs_q && hold_cnt == HOLD_W'(RST_HOLD - 1)) rv_q <= 1'b1;
      else if (rd_cfg)                              rv_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_o         = cfg_q;
    cfg_o[RS_BIT] = rs_q;
    cfg_o[RV_BIT] = rv_q;
  end

  always_comb begin
    case (rd_sel_i)
      SEL_OFFSET: rd_value_o = offset_o;
      SEL_GAIN:   rd_value_o = gain_o;
      SEL_CONFIG: rd_value_o = cfg_o;
      default:    rd_value_o = data_q;
    endcase
  end

  assign sys_rst_o = rs_q;

  a_r9_rv_needs_rs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rv_q) |-> $past(rs_q));
  a_r9_rv_write_immune: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !rd_cfg && !rs_q) |=> (rv_q == $past(rv_q)));
  a_r10_rv_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cfg && !rs_q) |=> !rv_q);
  a_r8_held_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rs_q |-> (cfg_q == '0 && offset_o == '0 && gain_o == GAIN_RST));
  a_r11_hold_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid_i && !conv_ready_o && !wr_cfg) |=> $stable(data_q));
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import scmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_HOLD = 8,
  parameter logic [31:0] GAIN_RST = 32'h0100_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_cs_n,
  input  logic        spi_sclk,
  input  logic        spi_mosi,
  output logic        spi_miso,
  input  logic        conv_valid,
  output logic        conv_ready,
  input  logic [31:0] conv_data,
  output logic        start_valid,
  output logic [1:0]  start_kind,
  output logic [31:0] cfg_word,
  output logic [31:0] offset_word,
  output logic [31:0] gain_word,
  output logic        soft_rst
);
  logic              cs_active, cmd_valid, word_valid, word_phase;
  logic [CMD_W-1:0]  cmd_byte;
  logic [WORD_W-1:0] rx_word, wr_data, rd_value;
  logic              rd_strobe, wr_strobe, data_readout;
  reg_sel_e          rd_sel, wr_sel;

  scmd_serial #(.SYNC_STAGES(SYNC_STAGES), .W(WORD_W), .CW(CMD_W)) u_serial (
    .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sclk_i(spi_sclk), .mosi_i(spi_mosi),
    .miso_o(spi_miso), .word_phase_i(word_phase), .tx_load_i(rd_strobe), .tx_word_i(rd_value),
    .cs_active_o(cs_active), .cmd_valid_o(cmd_valid), .cmd_byte_o(cmd_byte),
    .word_valid_o(word_valid), .word_o(rx_word)
  );

  scmd_ctrl #(.W(WORD_W), .CW(CMD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_active_i(cs_active), .cmd_valid_i(cmd_valid),
    .cmd_byte_i(cmd_byte), .word_valid_i(word_valid), .word_i(rx_word), .rs_active_i(soft_rst),
    .word_phase_o(word_phase), .rd_strobe_o(rd_strobe), .rd_sel_o(rd_sel),
    .wr_strobe_o(wr_strobe), .wr_sel_o(wr_sel), .wr_data_o(wr_data),
    .data_readout_o(data_readout), .start_valid_o(start_valid), .start_kind_o(start_kind)
  );

  scmd_regs #(.W(WORD_W), .RST_HOLD(RST_HOLD), .GAIN_RST(GAIN_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_strobe_i(wr_strobe), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_strobe_i(rd_strobe), .rd_sel_i(rd_sel), .rd_value_o(rd_value),
    .data_readout_i(data_readout), .conv_valid_i(conv_valid), .conv_data_i(conv_data),
    .conv_ready_o(conv_ready), .cfg_o(cfg_word), .offset_o(offset_word), .gain_o(gain_word),
    .sys_rst_o(soft_rst)
  );
endmodule

// File: tb/adc_serial_ctrl_tb.sv
module adc_serial_ctrl_tb;
  localparam int HALF = 8;
  localparam int NVEC = 8;
  // {is_read, cmd, write data, expected read data}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 32'hA5A5_0F0F, 32'h0},
    {1'b1, 8'h08, 32'h0,         32'hA5A5_0F0F},
    {1'b0, 8'h01, 32'h0123_4567, 32'h0},
    {1'b1, 8'h09, 32'h0,         32'h0123_4567},
    {1'b0, 8'h02, 32'hD0AB_CDEF, 32'h0},
    {1'b1, 8'h0A, 32'h0,         32'hC0AB_CDEF},
    {1'b0, 8'h00, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 8'h08, 32'h0,         32'hFFFF_FFFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0, spi_miso;
  logic conv_valid = 1'b0, conv_ready;
  logic [31:0] conv_data = '0;
  logic start_valid;
  logic [1:0] start_kind, last_kind;
  logic [31:0] cfg_word, offset_word, gain_word, rd;
  logic soft_rst;
  int checks = 0, errors = 0, start_cnt = 0, base;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_serial_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .conv_valid(conv_valid), .conv_ready(conv_ready), .conv_data(conv_data),
    .start_valid(start_valid), .start_kind(start_kind), .cfg_word(cfg_word),
    .offset_word(offset_word), .gain_word(gain_word), .soft_rst(soft_rst)
  );

  always @(posedge clk) if (start_valid) begin start_cnt++; last_kind = start_kind; end

  task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sbegin(); spi_cs_n = 1'b0; wclk(HALF); endtask
  task automatic send(); wclk(HALF); spi_cs_n = 1'b1; wclk(2*HALF); endtask

  task automatic sbit(input logic b, output logic m);
    spi_mosi = b; wclk(HALF); m = spi_miso;
    spi_sclk = 1'b1; wclk(HALF); spi_sclk = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] b);
    logic m;
    for (int i = 7; i >= 0; i--) sbit(b[i], m);
  endtask

  task automatic sword(input logic [31:0] w, output logic [31:0] r);
    for (int i = 31; i >= 0; i--) sbit(w[i], r[i]);
  endtask

  task automatic wr_reg(input logic [7:0] c, input logic [31:0] w);
    logic [31:0] r;
    sbegin(); sbyte(c); sword(w, r); send();
  endtask

  task automatic rd_reg(input logic [7:0] c, output logic [31:0] r);
    sbegin(); sbyte(c); sword(32'h0, r); send();
  endtask

  initial begin
    wclk(4); rst_n = 1'b1; wclk(4);
    // R1 reset state
    chk("R1 cfg", cfg_word, 32'h0);
    chk("R1 offset", offset_word, 32'h0);
    chk("R1 gain", gain_word, 32'h0100_0000);
    chk("R1 miso/ready/soft_rst", {29'h0, spi_miso, conv_ready, soft_rst}, 32'h2);

    // R2 R3 table walk (writes and MSB-first reads on falling edges)
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][72]) begin
        rd_reg(VEC[k][71:64], rd);
        chk("R2 R3 readback", rd, VEC[k][31:0]);
      end else wr_reg(VEC[k][71:64], VEC[k][63:32]);
    end
    chk("R9 write leaves rv clear", cfg_word, 32'hC0AB_CDEF);

    // R4 start commands, including two in one frame and a malformed one
    base = start_cnt;
    sbegin(); sbyte(8'h82); sbyte(8'h81); sbyte(8'h87); send();
    chk("R4 start count", start_cnt - base, 2);
    chk("R4 start kind", {30'h0, last_kind}, 32'h1);

    // R5 invalid byte then a write; data-register write ignored then a read
    wr_reg(8'h00, 32'h0);
    sbegin(); sbyte(8'h55); sbyte(8'h00); sword(32'h1234_5678, rd); send();
    chk("R5 command after invalid", offset_word, 32'h1234_5678);
    sbegin(); sbyte(8'h03); sbyte(8'h08); sword(32'h0, rd); send();
    chk("R5 write to data ignored", rd, 32'h1234_5678);

    // R6 abort mid-word
    sbegin(); sbyte(8'h00);
    for (int i = 0; i < 12; i++) sbit(1'b1, spi_mosi);
    send();
    chk("R6 abort keeps offset", offset_word, 32'h1234_5678);
    rd_reg(8'h08, rd);
    chk("R6 command mode after abort", rd, 32'h1234_5678);

    // R7 software reset
    wr_reg(8'h02, 32'h2000_0000);
    chk("R7 soft_rst", {31'h0, soft_rst}, 32'h1);
    chk("R7 offset cleared", offset_word, 32'h0);
    chk("R7 gain default", gain_word, 32'h0100_0000);
    chk("R9 rv set after hold", cfg_word, 32'h3000_0000);

    // R8 writes and starts ignored while held
    base = start_cnt;
    wr_reg(8'h00, 32'hDEAD_BEEF);
    wr_reg(8'h01, 32'h7777_7777);
    sbegin(); sbyte(8'h80); send();
    chk("R8 offset ignored", offset_word, 32'h0);
    chk("R8 gain ignored", gain_word, 32'h0100_0000);
    chk("R8 start ignored", start_cnt - base, 0);
    chk("R11 ready low in reset", {31'h0, conv_ready}, 32'h0);
    wr_reg(8'h02, 32'h0F00_00FF);
    chk("R8 field ignored on clear, rv kept", cfg_word, 32'h1000_0000);

    // R10 read returns then clears rv
    rd_reg(8'h0A, rd);
    chk("R10 read shows rv", rd, 32'h1000_0000);
    chk("R10 rv cleared", cfg_word, 32'h0);
    rd_reg(8'h0A, rd);
    chk("R10 second read", rd, 32'h0);
    wr_reg(8'h02, 32'h0000_0055);
    chk("R8 normal write after reset", cfg_word, 32'h0000_0055);

    // R11 conversion stream
    conv_data = 32'hCAFE_F00D; conv_valid = 1'b1; wclk(1); conv_valid = 1'b0;
    sbegin(); sbyte(8'h0B); wclk(4);
    chk("R11 ready low in readout", {31'h0, conv_ready}, 32'h0);
    conv_data = 32'h1111_1111; conv_valid = 1'b1; wclk(2); conv_valid = 1'b0;
    sword(32'h0, rd); send();
    chk("R11 readout value", rd, 32'hCAFE_F00D);
    chk("R11 ready restored", {31'h0, conv_ready}, 32'h1);
    rd_reg(8'h0B, rd);
    chk("R11 refused word not taken", rd, 32'hCAFE_F00D);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule